// File: doc/BRIEF.md
# LED Register Slave (User-Logic Side)

This block is the user-logic end of a small memory-mapped peripheral. It sits behind a bus adapter that has already decoded the address and broken each transfer into per-register chip-enable strobes, byte-lane enables, a write data word and handshake returns. The block holds one 32-bit data register that software can write and read back. The low eight bits of that register drive eight LED outputs, one LED per bit.

Each access targets the single register and lasts one cycle. The block answers in the same cycle the chip enable is raised. A write acknowledge accompanies any write strobe, and the register takes the enabled byte lanes on that clock edge. A read acknowledge accompanies any read strobe, and the register value is presented on the read bus while that acknowledge is high. Bursts do not exist on this interface. The error return is never raised.

Top module: `ledreg_slave`

## Requirements
- R1: The block holds one 32-bit register. A write with all four byte enables set, followed by a read, returns exactly the written word.
- R2: Byte-enable port bit k updates register bits 8k+7..8k on a write. Bit 0 is the least significant bit of the port, so a value of 4'b0011 updates only the two low bytes.
- R3: On a write, bytes whose enable bit is 0 keep their previous value. A write with all enables at 0 leaves the register unchanged.
- R4: `wr_ack` is high in exactly the cycles in which any bit of `wr_ce` is high. The register takes the new data on the rising edge that ends such a cycle.
- R5: `rd_ack` is high in exactly the cycles in which any bit of `rd_ce` is high. In those cycles `rd_data` equals the current register value.
- R6: `rd_data` is all zeros in every cycle in which `rd_ack` is low.
- R7: `led[i]` equals register bit i for i from 0 to 7. The LEDs change on the same edge as the register.
- R8: When `rst_n` is low at a rising edge, the register clears to zero, which turns all LEDs off. This reset is synchronous.
- R9: `err` is 0 at all times.
- R10: When a read and a write occur in the same cycle, the read returns the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_ce | input | CE_W | Write chip enable, one bit per register |
| rd_ce | input | CE_W | Read chip enable, one bit per register |
| be | input | DATA_W/8 | Byte-lane enables; bit k qualifies data byte k |
| wr_data | input | DATA_W | Write data word |
| rd_data | output | DATA_W | Read data; zero unless `rd_ack` is high |
| wr_ack | output | 1 | Write acknowledge |
| rd_ack | output | 1 | Read acknowledge |
| err | output | 1 | Error return, constant 0 |
| led | output | LED_W | LED drive, follows low register bits |

## Verification
The assertions assume the adapter upstream raises a chip enable for a single cycle per transfer. This follows from the single-register, no-burst nature of the interface. The ack-pulse checks are only meaningful under that assumption. The stimulus builds every transfer from a task that raises a strobe for exactly one clock and drops it before the next access. Random byte-enable patterns and data words are mixed with directed cases: no lanes enabled, a concurrent read and write, and a reset in the middle of a run.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;

    // Default geometry of the register slave.
    localparam int unsigned LEDREG_DATA_W = 32;
    localparam int unsigned LEDREG_LED_W  = 8;
    localparam int unsigned LEDREG_CE_W   = 1;

    // Number of byte lanes carried by a word of the given width.
    function automatic int unsigned lane_count(input int unsigned width);
        return width / 8;
    endfunction

endpackage

// File: rtl/ledreg_lane_merge.sv
// Byte-lane merge: picks each byte from the new word when its enable is set,
// otherwise keeps the byte of the old word.
module ledreg_lane_merge #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] merged
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[8*k +: 8] = lane_en[k] ? new_word[8*k +: 8] : old_word[8*k +: 8];
    end

endmodule

// File: rtl/ledreg_ack.sv
// Acknowledge generation: one-cycle answer to any raised chip-enable bit.
module ledreg_ack #(
    parameter int unsigned CE_W = 1
) (
    input  logic [CE_W-1:0] wr_ce,
    input  logic [CE_W-1:0] rd_ce,
    output logic            wr_ack,
    output logic            rd_ack
);

    always_comb begin
        wr_ack = |wr_ce;
        rd_ack = |rd_ce;
    end

endmodule

// File: rtl/ledreg_rdmux.sv
// Read return path: presents the register only while acknowledged.
module ledreg_rdmux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              rd_en,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = rd_en ? reg_word : '0;
    end

endmodule

// File: rtl/ledreg_slave.sv
module ledreg_slave
    import ledreg_pkg::*;
#(
    parameter int unsigned DATA_W = LEDREG_DATA_W,
    parameter int unsigned LED_W  = LEDREG_LED_W,
    parameter int unsigned CE_W   = LEDREG_CE_W,
    localparam int unsigned LANES = lane_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CE_W-1:0]   wr_ce,
    input  logic [CE_W-1:0]   rd_ce,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              rd_ack,
    output logic              err,
    output logic [LED_W-1:0]  led
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] merged;

    ledreg_ack #(.CE_W(CE_W)) u_ack (
        .wr_ce  (wr_ce),
        .rd_ce  (rd_ce),
        .wr_ack (wr_ack),
        .rd_ack (rd_ack)
    );

    ledreg_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (st_q.word),
        .new_word (wr_data),
        .lane_en  (be),
        .merged   (merged)
    );

    ledreg_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .rd_en    (rd_ack),
        .reg_word (st_q.word),
        .rd_data  (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ack) begin
            st_d.word = merged;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign led = st_q.word[LED_W-1:0];
    assign err = 1'b0;

    // ---------------- assertions ----------------
    AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && (&be)) |=> (st_q.word == $past(wr_data)));           // R1

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_LANE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack && be[k]) |=> (st_q.word[8*k +: 8] == $past(wr_data[8*k +: 8]))); // R2
        AST_LANE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_ack || !be[k]) |=> $stable(st_q.word[8*k +: 8]));      // R3
    end

    AST_WACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);                                            // R4
    AST_RACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);                                            // R5
    AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (rd_data == st_q.word));                             // R5
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |-> (rd_data == '0));                                   // R6
    AST_LED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (led == '0));                                  // R8
    AST_ERR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !err);                                                          // R9

endmodule

// File: tb/ledreg_slave_tb.sv
module ledreg_slave_tb;

    localparam int unsigned DW = 32;
    localparam int unsigned LW = 8;
    localparam int unsigned NL = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [0:0]    wr_ce = '0;
    logic [0:0]    rd_ce = '0;
    logic [NL-1:0] be = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_ack, rd_ack, err;
    logic [LW-1:0] led;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [DW-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ledreg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .rd_ce(rd_ce), .be(be),
        .wr_data(wr_data), .rd_data(rd_data), .wr_ack(wr_ack), .rd_ack(rd_ack),
        .err(err), .led(led)
    );

    function automatic logic [DW-1:0] merge_exp(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [NL-1:0] en);
        logic [DW-1:0] r = old_w;
        for (int k = 0; k < NL; k++) if (en[k]) r[8*k +: 8] = new_w[8*k +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-cycle write; checks ack while strobed and LEDs after the edge.
    task automatic do_write(input logic [NL-1:0] en, input logic [DW-1:0] d);
        @(negedge clk);
        wr_ce = 1'b1; be = en; wr_data = d;
        #1 check("R4 wr_ack high", {31'd0, wr_ack}, 32'd1);
        check("R9 err", {31'd0, err}, 32'd0);
        model = merge_exp(model, d, en);
        @(negedge clk);
        wr_ce = 1'b0; be = '0; wr_data = '0;
        #1 check("R4 wr_ack low", {31'd0, wr_ack}, 32'd0);
        check("R7 led", {24'd0, led}, {24'd0, model[LW-1:0]});
    endtask

    task automatic do_read(input string req);
        @(negedge clk);
        rd_ce = 1'b1;
        #1 check("R5 rd_ack high", {31'd0, rd_ack}, 32'd1);
        check(req, rd_data, model);
        @(negedge clk);
        rd_ce = 1'b0;
        #1 check("R6 rd_data idle", rd_data, '0);
        check("R5 rd_ack low", {31'd0, rd_ack}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h1EDC0DE));
        repeat (3) @(negedge clk);
        #1 check("R8 led in reset", {24'd0, led}, '0);
        check("R6 rd_data reset", rd_data, '0);
        rst_n = 1'b1;
        do_read("R8 cleared");

        // R1 full write/read
        do_write(4'hF, 32'hA5C3_0F96);
        do_read("R1 readback");
        do_write(4'hF, 32'h0000_00FF);
        do_read("R1 readback 2");

        // R2 partial lanes, low two bytes
        do_write(4'hF, 32'h1122_3344);
        do_write(4'b0011, 32'hDEAD_BEEF);
        do_read("R2 low lanes");
        check("R2 exact", model, 32'h1122_BEEF);

        // R3 no lanes enabled: nothing changes
        do_write(4'b0000, 32'hFFFF_FFFF);
        do_read("R3 no lanes");

        // R10 concurrent read and write returns old value
        @(negedge clk);
        wr_ce = 1'b1; rd_ce = 1'b1; be = 4'hF; wr_data = 32'h5555_AAAA;
        #1 check("R10 old value", rd_data, model);
        model = 32'h5555_AAAA;
        @(negedge clk);
        wr_ce = 1'b0; rd_ce = 1'b0; be = '0; wr_data = '0;
        do_read("R10 new value");

        // Random mix
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 2) != 0)
                do_write(4'($urandom_range(0, 15)), $urandom());
            else
                do_read("R2 R3 random read");
        end

        // R8 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        model = '0;
        @(negedge clk);
        #1 check("R8 led after reset", {24'd0, led}, '0);
        rst_n = 1'b1;
        do_read("R8 reg after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule